// File: doc/BRIEF.md
# Four-Channel Prioritised Block-Transfer Engine

This block moves blocks of bytes between memory and up to four peripherals without help from the host processor. The host programs a start address, a transfer length and a transfer kind for each channel through a small register port, and then enables the channel. A peripheral asks for service by raising its request line. The engine then asks the host for the bus and waits for the grant. Once it has the bus, it performs one transfer per grant of the arbiter. During each transfer it drives the memory address, the active-low acknowledge of the chosen channel, and the memory and I/O strobes that the kind of transfer calls for.

Transfers are single-beat and paced by a `ready` input. A low `ready` stretches the current transfer for as many cycles as needed. No data passes through the engine. The only handshakes are the request/acknowledge pair with the peripherals, the bus request/grant pair with the host, and the `ready` wait input. These are plain level signals, not stream interfaces. The engine flags the last transfer of each block on `tc`, and it flags every 128th completed transfer on `mark`.

Top module: `dma4_engine`

## Requirements
- R1: A request on a channel whose enable bit is clear is ignored. It raises neither `hrq` nor any acknowledge.
- R2: When several enabled channels are requesting, the lowest-numbered one is served. Channel 0 has the highest priority and channel 3 the lowest.
- R3: `hrq` rises one cycle after an enabled channel requests. No acknowledge or strobe goes active until `hlda` has been seen high while `hrq` is high.
- R4: The acknowledges `dack_n[3:0]` are active low. At most one is low at a time, and it stays low for the whole transfer of its channel.
- R5: During a transfer, `mem_addr` equals the channel's current address. After each completed transfer the address rises by one and the count falls by one.
- R6: `tc` is high during a transfer whose count register is 0. When that transfer completes, the channel clears its own enable and its count stays at 0. A count value of N therefore gives N+1 transfers.
- R7: The kind field `kind[1:0]` selects the strobes:
  - 2'b10 (read) drives `mem_rd_n` and `io_wr_n` low.
  - 2'b01 (write) drives `io_rd_n` and `mem_wr_n` low.
  - 2'b00 and 2'b11 (verify) leave all four strobes high.
- R8: While `ready` is low, the transfer holds: the acknowledge and `mem_addr` stay unchanged. The transfer completes on the first rising edge at which `ready` is high.
- R9: Reset clears every enable, address, count and kind, and leaves all acknowledges and strobes inactive.
- R10: `mark` is high during every 128th completed transfer, counted over all channels since reset.
- R11: `hrq` falls one cycle after the engine, between transfers, finds no enabled channel requesting.
- R12: Register map. The channel number is `cfg_sel[1:0]` and the field is `cfg_sel[3:2]`. The fields are:
  - Field 0: address.
  - Field 1: count in bits [13:0] and kind in bits [15:14].
  - Field 2: enable in bit 0.

  A write with `cfg_we` high takes effect at the next clock edge. `cfg_rdata` shows the selected field in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Field (bits 3:2) and channel (bits 1:0) select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Selected register contents |
| drq | input | 4 | Per-channel service requests |
| dack_n | output | 4 | Per-channel acknowledges, active low |
| hrq | output | 1 | Bus request to host |
| hlda | input | 1 | Bus grant from host |
| ready | input | 1 | Low inserts wait cycles |
| mem_addr | output | 16 | Transfer address |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | Peripheral read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| tc | output | 1 | Last transfer of a block |
| mark | output | 1 | Every 128th transfer |

## Verification
- `hrq` is due one cycle after an enabled channel is requesting.
- The acknowledge is due one cycle after `hlda` is seen in the requesting state.
- `tc`, `mark`, `mem_addr` and the strobes are valid for the whole acknowledge window.
- Register writes are visible on the next cycle.
- Because the arbiter runs between transfers, each completed transfer is followed by one non-transfer cycle.

The bench drives inputs just after the rising edge and samples on the falling edge. A transfer is scored on the falling edge that shows an acknowledge low together with `ready` high. At that point the bench checks the served channel, address, `tc`, `mark` and strobes against its own per-channel model, which it then advances.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [1:0] {
    XK_VFY0  = 2'b00,
    XK_WRITE = 2'b01,
    XK_READ  = 2'b10,
    XK_VFY1  = 2'b11
  } xfer_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CTRL = 2'd1;
  localparam logic [1:0] FLD_EN   = 2'd2;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan #(
  parameter int AW = 16,
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_ctrl,
  input  logic          wr_en,
  input  logic [AW-1:0] wdata,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt,
  output logic [1:0]    kind,
  output logic          en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
      kind <= '0;
      en   <= 1'b0;
    end else begin
      if (wr_addr) addr <= wdata;
      if (wr_ctrl) begin
        cnt  <= wdata[CW-1:0];
        kind <= wdata[AW-1:AW-2];
      end
      if (wr_en) en <= wdata[0];
      if (step) begin
        addr <= addr + 1'b1;
        if (cnt == '0) en  <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  p_tc_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step && (cnt == '0) |=> !en && (cnt == '0));
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && !wr_addr |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pending,
  output logic [CHW-1:0] win,
  output logic           any
);
  logic [NCH-1:0] lower_mask;

  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending[i]) win = CHW'(i);
    end
    any = |pending;
    lower_mask = (NCH'(1) << win) - NCH'(1);
  end

  always_comb begin
    if (any) begin
      p_prio_r2: assert ((pending & lower_mask) == '0 && pending[win]);
    end
  end
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq import dma4_pkg::*; #(
  parameter int NCH = 4,
  parameter int MARK_PERIOD = 128,
  localparam int CHW = $clog2(NCH),
  localparam int MW = $clog2(MARK_PERIOD)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_pend,
  input  logic [CHW-1:0] win,
  input  logic           hlda,
  input  logic           ready,
  output logic           hrq,
  output logic           xfer,
  output logic           done,
  output logic [CHW-1:0] cur,
  output logic           mark_now
);
  seq_state_e     state;
  logic [MW-1:0]  mcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
      mcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (any_pend) state <= ST_REQ;
        ST_REQ: begin
          if (!any_pend) state <= ST_IDLE;
          else if (hlda) begin
            cur   <= win;
            state <= ST_XFER;
          end
        end
        ST_XFER: if (ready) state <= ST_REQ;
        default: state <= ST_IDLE;
      endcase
      if (done) mcnt <= (mcnt == MW'(MARK_PERIOD - 1)) ? '0 : mcnt + 1'b1;
    end
  end

  assign hrq      = (state != ST_IDLE);
  assign xfer     = (state == ST_XFER);
  assign done     = xfer && ready;
  assign mark_now = xfer && (mcnt == MW'(MARK_PERIOD - 1));

  p_grant_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_XFER) && !(hrq && hlda) |=> state != ST_XFER);
  p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !ready |=> xfer && $stable(cur));
  p_hrq_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ) && !any_pend |=> !hrq);
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine import dma4_pkg::*; #(
  parameter int NCH = 4,
  parameter int AW = 16,
  parameter int CW = 14,
  parameter int MARK_PERIOD = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NCH)+1:0]   cfg_sel,
  input  logic [AW-1:0]            cfg_wdata,
  output logic [AW-1:0]            cfg_rdata,
  input  logic [NCH-1:0]           drq,
  output logic [NCH-1:0]           dack_n,
  output logic                     hrq,
  input  logic                     hlda,
  input  logic                     ready,
  output logic [AW-1:0]            mem_addr,
  output logic                     mem_rd_n,
  output logic                     mem_wr_n,
  output logic                     io_rd_n,
  output logic                     io_wr_n,
  output logic                     tc,
  output logic                     mark
);
  localparam int CHW = $clog2(NCH);

  logic [AW-1:0]  ch_addr [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  logic [1:0]     ch_kind [NCH];
  logic [NCH-1:0] ch_en;
  logic [NCH-1:0] pending;
  logic [CHW-1:0] win, cur, sel_ch;
  logic [1:0]     sel_fld;
  logic           any_pend, xfer, done;
  logic [1:0]     cur_kind;

  assign sel_ch  = cfg_sel[CHW-1:0];
  assign sel_fld = cfg_sel[CHW+1:CHW];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = cfg_we && (sel_ch == CHW'(i));
    dma4_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_addr (hit && sel_fld == FLD_ADDR),
      .wr_ctrl (hit && sel_fld == FLD_CTRL),
      .wr_en   (hit && sel_fld == FLD_EN),
      .wdata   (cfg_wdata),
      .step    (done && cur == CHW'(i)),
      .addr    (ch_addr[i]),
      .cnt     (ch_cnt[i]),
      .kind    (ch_kind[i]),
      .en      (ch_en[i])
    );
    assign pending[i] = ch_en[i] && drq[i];
    assign dack_n[i]  = !(xfer && cur == CHW'(i));
  end

  dma4_arb #(.NCH(NCH)) u_arb (
    .pending (pending),
    .win     (win),
    .any     (any_pend)
  );

  dma4_seq #(.NCH(NCH), .MARK_PERIOD(MARK_PERIOD)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_pend (any_pend),
    .win      (win),
    .hlda     (hlda),
    .ready    (ready),
    .hrq      (hrq),
    .xfer     (xfer),
    .done     (done),
    .cur      (cur),
    .mark_now (mark)
  );

  assign cur_kind = ch_kind[cur];
  assign mem_addr = ch_addr[cur];
  assign tc       = xfer && (ch_cnt[cur] == '0);

  always_comb begin
    mem_rd_n = 1'b1;
    mem_wr_n = 1'b1;
    io_rd_n  = 1'b1;
    io_wr_n  = 1'b1;
    if (xfer) begin
      case (xfer_kind_e'(cur_kind))
        XK_READ:  begin mem_rd_n = 1'b0; io_wr_n  = 1'b0; end
        XK_WRITE: begin io_rd_n  = 1'b0; mem_wr_n = 1'b0; end
        default:  ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (sel_fld)
      FLD_ADDR: cfg_rdata = ch_addr[sel_ch];
      FLD_CTRL: begin
        cfg_rdata[CW-1:0]    = ch_cnt[sel_ch];
        cfg_rdata[AW-1:AW-2] = ch_kind[sel_ch];
      end
      FLD_EN:   cfg_rdata[0] = ch_en[sel_ch];
      default:  cfg_rdata = '0;
    endcase
  end

  p_dack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));
  p_verify_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_n != '1) && (cur_kind == 2'b00 || cur_kind == 2'b11)
      |-> mem_rd_n && mem_wr_n && io_rd_n && io_wr_n);
  p_ack_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_n == '1) ##1 (dack_n != '1) |-> $past(hlda && hrq));
endmodule

// File: tb/tb_dma4_engine.sv
`timescale 1ns/1ps
module tb_dma4_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [3:0]  drq = '0;
  logic [3:0]  dack_n;
  logic        hrq;
  logic        hlda = 1'b0;
  logic        ready = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, tc, mark;

  always #4 clk = ~clk;

  dma4_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .drq(drq), .dack_n(dack_n),
    .hrq(hrq), .hlda(hlda), .ready(ready), .mem_addr(mem_addr),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .tc(tc), .mark(mark)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_addr [4];
  int          m_cnt  [4];
  logic [1:0]  m_kind [4];
  logic        m_en   [4];
  int m_mark = 0, m_total = 0, marks_seen = 0;
  int ob_ch, ob_w;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [3:0] exp_strobes(input logic [1:0] k);
    // order: mem_rd_n, mem_wr_n, io_rd_n, io_wr_n
    if (k == 2'b10) return 4'b0110;
    if (k == 2'b01) return 4'b1001;
    return 4'b1111;
  endfunction

  function automatic bit model_busy();
    for (int i = 0; i < 4; i++) if (m_en[i]) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = '0; m_cnt[i] = 0; m_kind[i] = '0; m_en[i] = 0;
    end
    m_mark = 0; m_total = 0; marks_seen = 0;
  endtask

  // scoreboard: one scored transfer per falling edge with ack low and ready high
  always @(negedge clk) begin
    if (rst_n && dack_n !== 4'hF && ready) begin
      ob_ch = -1; ob_w = -1;
      for (int i = 3; i >= 0; i--) if (!dack_n[i]) ob_ch = i;
      for (int i = 3; i >= 0; i--) if (m_en[i] && drq[i]) ob_w = i;
      chk("R2 served channel", ob_ch, ob_w);
      chk("R4 single ack", $countones(~dack_n), 1);
      if (ob_ch >= 0) begin
        chk("R5 address", mem_addr, m_addr[ob_ch]);
        chk("R6 tc", tc, (m_cnt[ob_ch] == 0));
        chk("R10 mark", mark, (m_mark == 127));
        chk("R7 strobes", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, exp_strobes(m_kind[ob_ch]));
        m_addr[ob_ch] = m_addr[ob_ch] + 16'd1;
        if (m_cnt[ob_ch] == 0) m_en[ob_ch] = 0; else m_cnt[ob_ch]--;
        m_mark = (m_mark == 127) ? 0 : m_mark + 1;
        m_total++;
        if (mark) marks_seen++;
      end
    end
  end

  task automatic wr(input logic [3:0] sel, input logic [15:0] d);
    @(posedge clk); #2;
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic prog(input int ch, input logic [15:0] a, input int n, input logic [1:0] k);
    wr({2'd0, 2'(ch)}, a);
    wr({2'd1, 2'(ch)}, {k, 14'(n)});
    m_addr[ch] = a; m_cnt[ch] = n; m_kind[ch] = k;
    wr({2'd2, 2'(ch)}, 16'd1);
    m_en[ch] = 1;
  endtask

  task automatic rd(input logic [3:0] sel, output logic [15:0] v);
    @(negedge clk);
    cfg_sel = sel;
    #1 v = cfg_rdata;
  endtask

  task automatic run_auto();
    while (model_busy() || hrq) begin
      @(posedge clk); #2;
      ready = ($urandom % 4) != 0;
      hlda  = hrq ? (hlda | ($urandom % 2 == 1)) : 1'b0;
    end
    @(posedge clk); #2;
    hlda = 0; ready = 1;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    logic [15:0] v;
    logic [3:0]  mask;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R9 reset hrq", hrq, 0);
    chk("R9 reset ack", dack_n, 4'hF);
    chk("R9 reset strobes", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, tc, mark}, 6'b111100);
    rd(4'b1000, v); chk("R9 reset enable", v, 0);

    // R12 register readback
    wr(4'b0010, 16'hBEEF);
    wr(4'b0110, {2'b01, 14'h0123});
    rd(4'b0010, v); chk("R12 address field", v, 16'hBEEF);
    rd(4'b0110, v); chk("R12 control field", v, 16'h4123);

    // R9 reset clears an enabled channel
    wr(4'b1010, 16'd1);
    rd(4'b1010, v); chk("R12 enable field", v, 1);
    @(posedge clk); #2 rst_n = 0;
    @(posedge clk); #2 rst_n = 1;
    rd(4'b1010, v); chk("R9 enable cleared", v, 0);
    rd(4'b0010, v); chk("R9 address cleared", v, 0);
    model_reset();

    // R1 disabled channels ignored
    drq = 4'hF;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R1 no hrq when disabled", hrq, 0);
    chk("R1 no ack when disabled", dack_n, 4'hF);
    drq = 0;

    // R3 nothing starts before grant
    drq = 4'b0001;
    prog(0, 16'h1000, 2, 2'b10);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R3 hrq raised", hrq, 1);
    chk("R3 no ack without grant", dack_n, 4'hF);
    chk("R3 no strobe without grant", {mem_rd_n, io_wr_n}, 2'b11);
    run_auto();
    rd(4'b1000, v); chk("R6 channel disabled", v, 0);
    rd(4'b0000, v); chk("R5 final address", v, 16'h1003);
    drq = 0;

    // R8 wait states
    ready = 0; hlda = 1; drq = 4'b0010;
    prog(1, 16'h2222, 0, 2'b01);
    while (dack_n[1]) @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R8 ack held", dack_n, 4'b1101);
      chk("R8 address held", mem_addr, 16'h2222);
    end
    @(posedge clk); #2 ready = 1;
    repeat (4) @(posedge clk);
    rd(4'b1001, v); chk("R6 self disable", v, 0);
    rd(4'b0101, v); chk("R6 count stays zero", v[13:0], 0);
    rd(4'b0001, v); chk("R5 address stepped", v, 16'h2223);
    hlda = 0; drq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R11 hrq dropped", hrq, 0);

    // R2 all channels at once, R10 long block
    drq = 4'hF;
    for (int i = 0; i < 4; i++) prog(i, 16'(16'h4000 + i * 16'h100), 1, 2'(i));
    run_auto();
    drq = 4'b0100;
    prog(2, 16'hFFF0, 199, 2'b00);
    run_auto();
    drq = 0;

    // constrained random rounds
    for (int r = 0; r < 40; r++) begin
      mask = 4'($urandom % 15 + 1);
      drq = mask | 4'($urandom);
      for (int i = 0; i < 4; i++)
        if (mask[i]) prog(i, 16'($urandom), $urandom % 12, 2'($urandom));
      run_auto();
      @(negedge clk); chk("R11 hrq low after round", hrq, 0);
      for (int i = 0; i < 4; i++) begin
        rd({2'd0, 2'(i)}, v); chk("R5 address after round", v, m_addr[i]);
        rd({2'd2, 2'(i)}, v); chk("R6 enable after round", v, 0);
      end
      drq = 0;
    end

    chk("R10 mark total", marks_seen, m_total / 128);
    wrap_up();
  end
endmodule